// File: doc/BRIEF.md
# Random Number Command and Status Controller

This block puts a register interface in front of a small behavioural pseudo-random generator whose state is loaded from an entropy input. Software writes a command code to the control register to either reseed the generator or ask it for a fresh batch of result words. A sequencer runs each command for a fixed number of cycles and drops any command written while a previous one is still running. Status bits report which operation is running, whether the generator holds a valid seed, and which output width is selected.

Results are read from eight consecutive word registers. In wide mode all eight words carry generator output. In narrow mode only the lower four do and the upper four read as zero. Three events latch into an interrupt status register, from which software clears them by writing ones: results ready, seed done, and generator lockup. A single interrupt line combines the latched flags through per-source enables and a global enable. A lockup happens when generation is asked of a generator whose state is all zeros. It withdraws the seeded status, so a new reseed is needed before generation can run again.

Top module: `rng_ctrl_top`

## Requirements
- R1: After reset the status, mode, interrupt enable, interrupt status and all result words read zero, and `irq` is low.
- R2: Writing 2 to the control register (offset 0x00) when idle starts a reseed. Status bit 31 is high for exactly SEED_LAT (default 10) cycles. In the cycle it falls, status bit 9 (seeded) rises, interrupt status bit 1 sets, and every result word becomes zero.
- R3: Writing 1 to the control register when idle and seeded starts a generate. Status bit 30 is high for exactly GEN_LAT (default 6) cycles. In the cycle it falls, interrupt status bit 0 sets and the result words (offsets 0x20 + 4*k) are updated.
- R4: Mode register (0x08) bit 3 selects the output width: 1 means eight valid words, 0 means four valid words, and words 4..7 are then written as zero. Status bit 3 mirrors mode bit 3. The width is sampled when a generate starts.
- R5: A generate command given while the block has no seed is ignored: no busy bit, no interrupt flag, result words unchanged.
- R6: A command written while either busy bit is high is dropped. Command value 0, and values other than 1 and 2, have no effect.
- R7: Interrupt status (0x14) bits 0, 1 and 4 are cleared by writing 1 to them; writing 0 leaves a bit as it is.
- R8: `irq` is high only when interrupt enable (0x10) bit 31 is set and, for some source bit b in {0,1,4}, enable bit b and status bit b are both set.
- R9: A generate command given while seeded but with an all-zero generator state does not run. It sets interrupt status bit 4 and clears status bit 9, so later generates are ignored until the next reseed.
- R10: A reseed loads the generator state with `entropy_in` as sampled in the cycle the command is accepted. The step function is a right shift that XORs 0x80200003 into the result when the bit shifted out is 1. Word k holds the state after k+1 steps. The state carries on after eight steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| entropy_in | input | 32 | Entropy word sampled when a reseed is accepted |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that writes arrive as single-cycle strobes on word-aligned addresses. They also take for granted that `entropy_in` is steady during the cycle a reseed is accepted, since the expected generator output is derived from that one sample. The stimulus raises `bus_wr` for one clock per access and changes `entropy_in` only while the block is idle. It waits for both busy bits to drop before issuing the next command, except where it tests that commands are dropped. A zero entropy word is supplied on purpose in one test only, to provoke the lockup path.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
  localparam int WORD_W = 32;

  // register offsets (software decodes these)
  localparam logic [7:0] OFF_CMD   = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_MODE  = 8'h08;
  localparam logic [7:0] OFF_IEN   = 8'h10;
  localparam logic [7:0] OFF_IFLG  = 8'h14;
  localparam logic [7:0] OFF_RES   = 8'h20;

  // command codes
  localparam logic [WORD_W-1:0] CODE_GEN  = 32'd1;
  localparam logic [WORD_W-1:0] CODE_SEED = 32'd2;

  // bit positions
  localparam int B_WIDE     = 3;
  localparam int B_SEEDED   = 9;
  localparam int B_GENBUSY  = 30;
  localparam int B_SEEDBUSY = 31;
  localparam int B_RDY      = 0;
  localparam int B_SDONE    = 1;
  localparam int B_LOCK     = 4;
  localparam int B_GLOBAL   = 31;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_GEN  = 2'd1,
    SQ_SEED = 2'd2
  } sq_state_e;

  // one generator step: shift right, fold taps in when the dropped bit is 1
  function automatic logic [WORD_W-1:0] lfsr_adv(input logic [WORD_W-1:0] s,
                                                 input logic [WORD_W-1:0] taps);
    logic [WORD_W-1:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ taps;
    return r;
  endfunction

  // interrupt combination: global enable gating per-source matches
  function automatic logic irq_calc(input logic glb, input logic [2:0] en,
                                    input logic [2:0] flg);
    return glb & (|(en & flg));
  endfunction
endpackage

// File: rtl/rngc_core.sv
module rngc_core
  import rngc_pkg::*;
#(
  parameter int              N_WORDS = 8,
  parameter logic [WORD_W-1:0] TAPS  = 32'h8020_0003
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [WORD_W-1:0]               entropy_in,
  input  logic                            mode_wide,
  input  logic                            seed_start,
  input  logic                            seed_done,
  input  logic                            gen_start,
  input  logic                            gen_done,
  input  logic                            lock_evt,
  output logic                            seeded,
  output logic                            locked,
  output logic [N_WORDS-1:0][WORD_W-1:0]  words
);
  localparam int HALF = N_WORDS / 2;

  logic [WORD_W-1:0]              state_q;
  logic [WORD_W-1:0]              seed_pend_q;
  logic                           wide_q;
  logic                           seeded_q;
  logic [N_WORDS-1:0][WORD_W-1:0] words_q;
  logic [N_WORDS-1:0][WORD_W-1:0] nxt_words;
  logic [WORD_W-1:0]              end_state;

  always_comb begin
    logic [WORD_W-1:0] s;
    s = state_q;
    for (int i = 0; i < N_WORDS; i++) begin
      s = lfsr_adv(s, TAPS);
      nxt_words[i] = (wide_q || i < HALF) ? s : '0;
    end
    end_state = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= '0;
      seed_pend_q <= '0;
      wide_q      <= 1'b0;
      seeded_q    <= 1'b0;
      words_q     <= '0;
    end else begin
      if (seed_start) seed_pend_q <= entropy_in;
      if (gen_start)  wide_q      <= mode_wide;
      if (seed_done) begin
        state_q  <= seed_pend_q;
        words_q  <= '0;
        seeded_q <= 1'b1;
      end else if (gen_done) begin
        state_q <= end_state;
        words_q <= nxt_words;
      end
      if (lock_evt) seeded_q <= 1'b0;
    end
  end

  assign seeded = seeded_q;
  assign locked = (state_q == '0);
  assign words  = words_q;

  AST_SEED_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    seed_done |=> (words == '0) && seeded); // R2

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_done && !wide_q) |=> (words[N_WORDS-1:HALF] == '0)); // R4

  AST_GEN_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_done && !locked) |=> !locked); // R10

  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_evt && !seed_done && !gen_done) |=> $stable(words)); // R9
endmodule

// File: rtl/rngc_seq.sv
module rngc_seq
  import rngc_pkg::*;
#(
  parameter int GEN_LAT  = 6,
  parameter int SEED_LAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_gen,
  input  logic cmd_seed,
  input  logic seeded,
  input  logic locked,
  output logic gen_busy,
  output logic seed_busy,
  output logic gen_start,
  output logic seed_start,
  output logic gen_done,
  output logic seed_done,
  output logic lock_evt
);
  localparam int MAX_LAT = (GEN_LAT > SEED_LAT) ? GEN_LAT : SEED_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  sq_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idle;

  assign idle       = (st_q == SQ_IDLE);
  assign gen_start  = idle && cmd_gen && seeded && !locked;
  assign lock_evt   = idle && cmd_gen && seeded && locked;
  assign seed_start = idle && cmd_seed;
  assign gen_done   = (st_q == SQ_GEN)  && (cnt_q == '0);
  assign seed_done  = (st_q == SQ_SEED) && (cnt_q == '0);
  assign gen_busy   = (st_q == SQ_GEN);
  assign seed_busy  = (st_q == SQ_SEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (seed_start) begin
            st_q  <= SQ_SEED;
            cnt_q <= CNT_W'(SEED_LAT - 1);
          end else if (gen_start) begin
            st_q  <= SQ_GEN;
            cnt_q <= CNT_W'(GEN_LAT - 1);
          end
        end
        SQ_GEN, SQ_SEED: begin
          if (cnt_q == '0) st_q <= SQ_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gen_busy, seed_busy})); // R6

  AST_GEN_NEEDS_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    gen_start |-> seeded && !locked); // R5

  AST_SEED_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seed_done |=> !seed_busy && !gen_busy); // R2

  AST_GEN_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_done |=> !gen_busy && !seed_busy); // R3

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_busy && !gen_done) |=> gen_busy); // R6
endmodule

// File: rtl/rngc_regs.sv
module rngc_regs
  import rngc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int N_WORDS = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [WORD_W-1:0]               bus_wdata,
  output logic [WORD_W-1:0]               bus_rdata,
  output logic                            irq,
  output logic                            cmd_gen,
  output logic                            cmd_seed,
  output logic                            mode_wide,
  input  logic                            gen_busy,
  input  logic                            seed_busy,
  input  logic                            seeded,
  input  logic [N_WORDS-1:0][WORD_W-1:0]  words,
  input  logic                            ev_gen_done,
  input  logic                            ev_seed_done,
  input  logic                            ev_lock
);
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int RES_SZ = N_WORDS * 4;

  logic       wide_q;
  logic       glb_q;
  logic [2:0] ien_q;   // {lock, seed done, ready}
  logic [2:0] flg_q;
  logic [2:0] ev_vec;
  logic [2:0] clr_vec;
  logic       wr_cmd, wr_mode, wr_ien, wr_flg;

  assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
  assign wr_mode = bus_wr && (bus_addr == ADDR_W'(OFF_MODE));
  assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(OFF_IEN));
  assign wr_flg  = bus_wr && (bus_addr == ADDR_W'(OFF_IFLG));

  assign cmd_gen  = wr_cmd && (bus_wdata == CODE_GEN);
  assign cmd_seed = wr_cmd && (bus_wdata == CODE_SEED);

  assign ev_vec  = {ev_lock, ev_seed_done, ev_gen_done};
  assign clr_vec = wr_flg ? {bus_wdata[B_LOCK], bus_wdata[B_SDONE], bus_wdata[B_RDY]} : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      glb_q  <= 1'b0;
      ien_q  <= '0;
      flg_q  <= '0;
    end else begin
      if (wr_mode) wide_q <= bus_wdata[B_WIDE];
      if (wr_ien) begin
        glb_q <= bus_wdata[B_GLOBAL];
        ien_q <= {bus_wdata[B_LOCK], bus_wdata[B_SDONE], bus_wdata[B_RDY]};
      end
      flg_q <= (flg_q & ~clr_vec) | ev_vec;
    end
  end

  assign mode_wide = wide_q;
  assign irq       = irq_calc(glb_q, ien_q, flg_q);

  // result window decode
  logic [ADDR_W-1:0] res_off;
  logic              res_hit;
  logic [IDX_W-1:0]  res_idx;

  assign res_off = bus_addr - ADDR_W'(OFF_RES);
  assign res_hit = (bus_addr >= ADDR_W'(OFF_RES)) && (res_off < ADDR_W'(RES_SZ))
                   && (res_off[1:0] == 2'b00);
  assign res_idx = res_off[IDX_W+1:2];

  always_comb begin
    bus_rdata = '0;
    if (res_hit) begin
      bus_rdata = words[res_idx];
    end else begin
      unique case (bus_addr)
        ADDR_W'(OFF_STAT): begin
          bus_rdata[B_SEEDBUSY] = seed_busy;
          bus_rdata[B_GENBUSY]  = gen_busy;
          bus_rdata[B_SEEDED]   = seeded;
          bus_rdata[B_WIDE]     = wide_q;
        end
        ADDR_W'(OFF_MODE): bus_rdata[B_WIDE] = wide_q;
        ADDR_W'(OFF_IEN): begin
          bus_rdata[B_GLOBAL] = glb_q;
          bus_rdata[B_LOCK]   = ien_q[2];
          bus_rdata[B_SDONE]  = ien_q[1];
          bus_rdata[B_RDY]    = ien_q[0];
        end
        ADDR_W'(OFF_IFLG): begin
          bus_rdata[B_LOCK]  = flg_q[2];
          bus_rdata[B_SDONE] = flg_q[1];
          bus_rdata[B_RDY]   = flg_q[0];
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_RDY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gen_done |=> flg_q[0]); // R3

  AST_SDONE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seed_done |=> flg_q[1]); // R2

  AST_W1C_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flg && bus_wdata[B_RDY] && !ev_gen_done) |=> !flg_q[0]); // R7

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glb_q && (flg_q != 3'b000)); // R8

  AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> flg_q[2]); // R9
endmodule

// File: rtl/rng_ctrl_top.sv
module rng_ctrl_top
  import rngc_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              N_WORDS  = 8,
  parameter int              GEN_LAT  = 6,
  parameter int              SEED_LAT = 10,
  parameter logic [31:0]     TAPS     = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       entropy_in,
  output logic              irq
);
  logic cmd_gen, cmd_seed, mode_wide;
  logic gen_busy, seed_busy, gen_start, seed_start, gen_done, seed_done, lock_evt;
  logic seeded, locked;
  logic [N_WORDS-1:0][WORD_W-1:0] words;

  rngc_regs #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .cmd_gen(cmd_gen), .cmd_seed(cmd_seed), .mode_wide(mode_wide),
    .gen_busy(gen_busy), .seed_busy(seed_busy), .seeded(seeded), .words(words),
    .ev_gen_done(gen_done), .ev_seed_done(seed_done), .ev_lock(lock_evt)
  );

  rngc_seq #(.GEN_LAT(GEN_LAT), .SEED_LAT(SEED_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_gen(cmd_gen), .cmd_seed(cmd_seed),
    .seeded(seeded), .locked(locked), .gen_busy(gen_busy), .seed_busy(seed_busy),
    .gen_start(gen_start), .seed_start(seed_start), .gen_done(gen_done),
    .seed_done(seed_done), .lock_evt(lock_evt)
  );

  rngc_core #(.N_WORDS(N_WORDS), .TAPS(TAPS)) u_core (
    .clk(clk), .rst_n(rst_n), .entropy_in(entropy_in), .mode_wide(mode_wide),
    .seed_start(seed_start), .seed_done(seed_done), .gen_start(gen_start),
    .gen_done(gen_done), .lock_evt(lock_evt), .seeded(seeded), .locked(locked),
    .words(words)
  );

  AST_LOCK_CLEARS_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_evt && !seed_done) |=> !seeded); // R9
endmodule

// File: tb/tb_rng_ctrl_top.sv
module tb_rng_ctrl_top;
  localparam int GEN_LAT  = 6;
  localparam int SEED_LAT = 10;
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] entropy_in = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rng_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entropy_in(entropy_in), .irq(irq)
  );

  // seed and wide flag per entry: {wide, seed}
  localparam logic [32:0] VECS [4] = '{
    {1'b1, 32'h1234_5678},
    {1'b0, 32'hDEAD_BEEF},
    {1'b1, 32'h0000_0001},
    {1'b0, 32'hFFFF_FFFF}
  };

  function automatic logic [31:0] bstep(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(8'h04, s);
      if (s[31:30] == 2'b00) return;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] st;
    logic [31:0] exp_w [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h04, d); check("R1 status", d, 32'h0);
    rd(8'h08, d); check("R1 mode", d, 32'h0);
    rd(8'h10, d); check("R1 ien", d, 32'h0);
    rd(8'h14, d); check("R1 iflag", d, 32'h0);
    rd(8'h3C, d); check("R1 word7", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R5 generate without seed
    wr(8'h00, 32'd1);
    peek(8'h04, d); check("R5 no busy", d, 32'h0);
    repeat (GEN_LAT + 2) @(negedge clk);
    rd(8'h14, d); check("R5 no flag", d, 32'h0);
    rd(8'h20, d); check("R5 word0 unchanged", d, 32'h0);

    // R2 reseed latency
    entropy_in = 32'hCAFE_0001;
    wr(8'h00, 32'd2);
    peek(8'h04, d); check("R2 seed busy start", {31'b0, d[31]}, 32'h1);
    repeat (SEED_LAT - 1) @(negedge clk);
    peek(8'h04, d); check("R2 seed busy last", {31'b0, d[31]}, 32'h1);
    @(negedge clk);
    peek(8'h04, d); check("R2 idle+seeded", d, 32'h0000_0200);
    peek(8'h14, d); check("R2 seed done flag", d, 32'h2);

    // R3 generate latency, narrow mode from seed CAFE0001
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd1);
    peek(8'h04, d); check("R3 gen busy start", {31'b0, d[30]}, 32'h1);
    repeat (GEN_LAT - 1) @(negedge clk);
    peek(8'h04, d); check("R3 gen busy last", {31'b0, d[30]}, 32'h1);
    @(negedge clk);
    peek(8'h04, d); check("R3 idle", {30'b0, d[31:30]}, 32'h0);
    peek(8'h14, d); check("R3 ready flag", d, 32'h1);
    st = 32'hCAFE_0001;
    st = bstep(st);
    rd(8'h20, d); check("R10 word0 after seed", d, st);
    rd(8'h30, d); check("R4 narrow word4 zero", d, 32'h0);

    // vector table: reseed, generate, compare all words
    foreach (VECS[v]) begin
      wr(8'h08, {28'b0, VECS[v][32], 3'b000});
      rd(8'h04, d); check("R4 status mirrors mode", {31'b0, d[3]}, {31'b0, VECS[v][32]});
      entropy_in = VECS[v][31:0];
      wr(8'h00, 32'd2);
      wait_idle();
      wr(8'h14, 32'h13);
      wr(8'h00, 32'd1);
      wait_idle();
      st = VECS[v][31:0];
      for (int k = 0; k < 8; k++) begin
        st = bstep(st);
        exp_w[k] = (VECS[v][32] || k < 4) ? st : 32'h0;
      end
      for (int k = 0; k < 8; k++) begin
        rd(8'h20 + 8'(4 * k), d);
        check("R10 R4 result word", d, exp_w[k]);
      end
      // second generate continues from carried state
      wr(8'h00, 32'd1);
      wait_idle();
      st = bstep(st);
      rd(8'h20, d); check("R10 carried state", d, st);
    end

    // R6 command while busy dropped; nop and unknown code ignored
    wr(8'h14, 32'h13);
    entropy_in = 32'h0BAD_F00D;
    wr(8'h00, 32'd2);
    wr(8'h00, 32'd1);
    wait_idle();
    rd(8'h14, d); check("R6 gen dropped while busy", d, 32'h2);
    rd(8'h04, d); check("R6 no gen pending", {30'b0, d[31:30]}, 32'h0);
    rd(8'h20, d); check("R2 reseed zeroes words", d, 32'h0);
    wr(8'h00, 32'd0);
    peek(8'h04, d); check("R6 nop no busy", {30'b0, d[31:30]}, 32'h0);
    wr(8'h00, 32'd3);
    peek(8'h04, d); check("R6 code3 no busy", {30'b0, d[31:30]}, 32'h0);
    rd(8'h14, d); check("R6 flags unchanged", d, 32'h2);

    // R7 write-one-to-clear
    wr(8'h00, 32'd1);
    wait_idle();
    rd(8'h14, d); check("R7 both flags", d, 32'h3);
    wr(8'h14, 32'h0);
    rd(8'h14, d); check("R7 zero write keeps", d, 32'h3);
    wr(8'h14, 32'h1);
    rd(8'h14, d); check("R7 clear ready only", d, 32'h2);

    // R8 interrupt gating (flag bit1 set)
    wr(8'h10, 32'h0000_0002);
    check("R8 no global", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0001);
    check("R8 wrong source", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0002);
    check("R8 matching source", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h2);
    check("R8 cleared flag", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h0);

    // R9 lockup from zero seed
    entropy_in = 32'h0;
    wr(8'h00, 32'd2);
    wait_idle();
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd1);
    peek(8'h04, d); check("R9 no busy on lockup", {30'b0, d[31:30]}, 32'h0);
    peek(8'h14, d); check("R9 lock flag", d, 32'h10);
    peek(8'h04, d); check("R9 seeded cleared", {31'b0, d[9]}, 32'h0);
    wr(8'h14, 32'h10);
    wr(8'h00, 32'd1);
    repeat (GEN_LAT + 2) @(negedge clk);
    rd(8'h14, d); check("R9 gen ignored after lock", d, 32'h0);
    entropy_in = 32'h0000_0010;
    wr(8'h00, 32'd2);
    wait_idle();
    wr(8'h00, 32'd1);
    wait_idle();
    rd(8'h14, d); check("R9 gen after reseed", d, 32'h3);
    rd(8'h20, d); check("R9 word0 after reseed", d, bstep(32'h10));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule